// File: doc/BRIEF.md
# Mode-Decoded One-Time-Programmable Byte Array

This block is a synchronous, synthesizable model of a byte-wide programmable read-only store. A set of active-low strobes (chip select, output enable, program strobe) and two digital flags (programming supply raised, identity high-voltage present) are decoded each cycle into one of seven operating modes. These modes are read, program, program verify, program inhibit, standby, output disable and identity readout. The full-size configuration is 16384 bytes with a 14-bit address. The default build is smaller, and the address width is a parameter.

Cells behave like fused bits. An erased cell holds 1. A program cycle ANDs the write byte into the stored byte, so a cleared bit can only return to 1 through the synchronous bulk-erase input, which sets every word to all ones at one clock edge. There is no tristate pin. The block drives a registered data byte together with a registered drive-enable flag. The data byte is held at zero whenever the drive-enable flag is low. Outputs reflect the inputs present at the previous rising edge.

Top module: `prom_array_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with the block in standby, rd_drive is 0 and rd_data is 0.
- R2: Read mode (chip_sel_n=0, out_en_n=0, prog_n=1, hv_prog=0, hv_ident=0) sets rd_drive=1 and rd_data to the stored byte at addr after the next rising edge.
- R3: Program mode (chip_sel_n=0, out_en_n=1, prog_n=0, hv_prog=1) updates the word at addr to (stored AND wr_data) and does not drive the output.
- R4: Programming never turns a 0 bit into 1. Writing 8'hFF leaves a word unchanged.
- R5: Verify mode (chip_sel_n=0, out_en_n=0, prog_n=1, hv_prog=1) drives the stored byte at addr, whatever hv_ident is.
- R6: Program inhibit (chip_sel_n=1, hv_prog=1) leaves the output undriven and writes nothing.
- R7: Standby (chip_sel_n=1, hv_prog=0) and output disable (chip_sel_n=0, out_en_n=1, not a program cycle) leave the output undriven and write nothing.
- R8: Identity mode (read strobes with hv_ident=1 and hv_prog=0) drives MAKER_ID when addr[0]=0 and PART_ID when addr[0]=1, in place of array data.
- R9: Whenever rd_drive is 0, rd_data is 0.
- R10: bulk_erase=1 sets every word to all ones at that edge and takes priority over a program cycle in the same cycle.
- R11: chip_sel_n=0, out_en_n=0 and prog_n=0 together leave the output undriven and write nothing.
- R12: A word written at one edge is what a read issued in the following cycle returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| hv_prog | input | 1 | Programming supply raised |
| hv_ident | input | 1 | Identity high voltage present |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Byte to program |
| bulk_erase | input | 1 | Synchronous erase of all words to ones |
| rd_data | output | DATA_W | Registered output byte, zero when not driven |
| rd_drive | output | 1 | Registered output drive enable |

## Verification
The bench builds the block with ADDR_W=6, which gives 64 words. Every word can therefore be swept after a bulk erase, and a full-array erase can be proven cell by cell within a short run. The identity codes are set to 8'h29 and 8'hB6, which differ from the defaults. An identity readout can then only match if the parameter path is honoured, and the two codes cannot be mistaken for erased or programmed array contents.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_INHIBIT = 3'd1,
        MD_OUT_OFF = 3'd2,
        MD_PROGRAM = 3'd3,
        MD_READ    = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_IDENT   = 3'd6
    } prom_mode_e;

    function automatic logic mode_drives(prom_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
    endfunction

    function automatic logic mode_writes(prom_mode_e m);
        return (m == MD_PROGRAM);
    endfunction

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
    import prom_pkg::*;
(
    input  logic       chip_sel_n,
    input  logic       out_en_n,
    input  logic       prog_n,
    input  logic       hv_prog,
    input  logic       hv_ident,
    output prom_mode_e mode
);

    always_comb begin
        if (chip_sel_n) begin
            // deselected: supply level picks inhibit or standby, both float
            mode = hv_prog ? MD_INHIBIT : MD_STANDBY;
        end else if (out_en_n) begin
            mode = (!prog_n && hv_prog) ? MD_PROGRAM : MD_OUT_OFF;
        end else if (!prog_n) begin
            // both output enable and program strobe low: not a legal mode
            mode = MD_OUT_OFF;
        end else if (hv_prog) begin
            mode = MD_VERIFY;
        end else if (hv_ident) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic              sel;
        logic [DATA_W-1:0] word_d;
        logic [DATA_W-1:0] word_q;

        assign sel = wr_en && (wr_addr == ADDR_W'(w));

        always_comb begin
            word_d = word_q;
            if (erase) begin
                word_d = '1;
            end else if (sel) begin
                word_d = word_q & wr_data;
            end
        end

        always_ff @(posedge clk) begin
            word_q <= word_d;
        end

        assign words[w] = word_q;
    end

    assign rd_word = words[rd_addr];

endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
    import prom_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h15,
    parameter logic [DATA_W-1:0] PART_ID  = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prom_mode_e        mode,
    input  logic              id_sel,
    input  logic [DATA_W-1:0] cell_word,
    output logic [DATA_W-1:0] out_data,
    output logic              out_drive
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    always_comb begin
        state_d = '0;
        if (mode_drives(mode)) begin
            state_d.drive = 1'b1;
            if (mode == MD_IDENT) begin
                state_d.data = id_sel ? PART_ID : MAKER_ID;
            end else begin
                state_d.data = cell_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_data  = state_q.data;
    assign out_drive = state_q.drive;

endmodule

// File: rtl/prom_array_top.sv
module prom_array_top
    import prom_pkg::*;
#(
    parameter int              ADDR_W   = 11,
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h15,
    parameter logic [DATA_W-1:0] PART_ID  = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_n,
    input  logic              hv_prog,
    input  logic              hv_ident,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bulk_erase,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    prom_mode_e        mode;
    logic              cell_we;
    logic [DATA_W-1:0] cell_word;

    prom_mode_decode u_decode (
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .prog_n     (prog_n),
        .hv_prog    (hv_prog),
        .hv_ident   (hv_ident),
        .mode       (mode)
    );

    // erase wins over a program strobe in the same cycle
    assign cell_we = mode_writes(mode) && !bulk_erase;

    prom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk     (clk),
        .wr_en   (cell_we),
        .erase   (bulk_erase),
        .wr_addr (addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_word (cell_word)
    );

    prom_out_stage #(
        .DATA_W   (DATA_W),
        .MAKER_ID (MAKER_ID),
        .PART_ID  (PART_ID)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .id_sel    (addr[0]),
        .cell_word (cell_word),
        .out_data  (rd_data),
        .out_drive (rd_drive)
    );

endmodule

// File: rtl/prom_array_chk.sv
module prom_array_chk #(
    parameter int              ADDR_W   = 11,
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h15,
    parameter logic [DATA_W-1:0] PART_ID  = 8'h83
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              out_en_n,
    input logic              prog_n,
    input logic              hv_prog,
    input logic              hv_ident,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              bulk_erase,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive
);

    logic rd_strobes;
    assign rd_strobes = !chip_sel_n && !out_en_n && prog_n;

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    // R2 R5 R8 R11: drive only follows a cycle with the read strobes set
    assert_drive_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(rd_strobes));

    // R6 R7: a deselected chip never drives
    assert_desel_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_sel_n) |-> !rd_drive);

    assert_ident_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_strobes) && $past(!hv_prog) && $past(hv_ident))
        |-> (rd_data == ($past(addr[0]) ? PART_ID : MAKER_ID)));

    assert_erase_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bulk_erase, 2) && $past(rd_strobes) && $past(!hv_ident))
        |-> (rd_drive && rd_data == '1));

endmodule

bind prom_array_top prom_array_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MAKER_ID (MAKER_ID),
    .PART_ID  (PART_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .prog_n     (prog_n),
    .hv_prog    (hv_prog),
    .hv_ident   (hv_ident),
    .addr       (addr),
    .wr_data    (wr_data),
    .bulk_erase (bulk_erase),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive)
);

// File: tb/prom_array_top_bench.sv
module prom_array_top_bench;

    localparam int         AW    = 6;
    localparam int         NW    = 1 << AW;
    localparam logic [7:0] MAKER = 8'h29;
    localparam logic [7:0] PART  = 8'hB6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_sel_n, out_en_n, prog_n, hv_prog, hv_ident, bulk_erase;
    logic [AW-1:0] addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          rd_drive;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic       chk;
        logic       drive;
        logic [7:0] data;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    exp_t  cur;
    string cur_tag;

    logic [7:0] model [NW];

    always #10 clk = ~clk;

    prom_array_top #(
        .ADDR_W   (AW),
        .DATA_W   (8),
        .MAKER_ID (MAKER),
        .PART_ID  (PART)
    ) u_prom_array_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .prog_n     (prog_n),
        .hv_prog    (hv_prog),
        .hv_ident   (hv_ident),
        .addr       (addr),
        .wr_data    (wr_data),
        .bulk_erase (bulk_erase),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive)
    );

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: one call is one clock cycle
    task automatic apply(input logic cs, input logic oe, input logic pg,
                         input logic hvp, input logic hvi, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic er, input bit chk,
                         input string tag);
        exp_t e;
        @(negedge clk);
        chip_sel_n = cs; out_en_n = oe; prog_n = pg;
        hv_prog = hvp; hv_ident = hvi; addr = a; wr_data = d; bulk_erase = er;
        e.chk   = chk;
        e.drive = !cs && !oe && pg;
        e.data  = 8'h00;
        if (e.drive) begin
            if (!hvp && hvi) e.data = a[0] ? PART : MAKER;
            else             e.data = model[a];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (er) begin
            for (int i = 0; i < NW; i++) model[i] = 8'hFF;
        end else if (!cs && oe && !pg && hvp) begin
            model[a] = model[a] & d;
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        apply(0, 0, 1, 0, 0, a, 8'h00, 0, 1, tag);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        apply(0, 1, 0, 1, 0, a, d, 0, 1, tag);
    endtask

    // monitor: outputs settle after the edge, compare mid-cycle
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            if (cur.chk) begin
                total++;
                if (rd_drive !== cur.drive || rd_data !== cur.data) begin
                    bad++;
                    $display("FAIL %s: actual drive=%0b data=%h, expected drive=%0b data=%h",
                             cur_tag, rd_drive, rd_data, cur.drive, cur.data);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        rst_n = 0;
        chip_sel_n = 1; out_en_n = 1; prog_n = 1;
        hv_prog = 0; hv_ident = 0; bulk_erase = 0;
        addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        total++;
        if (rd_drive !== 1'b0 || rd_data !== 8'h00) begin
            bad++;
            $display("FAIL R1 in reset: actual drive=%0b data=%h, expected drive=0 data=00",
                     rd_drive, rd_data);
        end
        rst_n = 1;
        apply(1, 1, 1, 0, 0, '0, 8'h00, 0, 1, "R1 after reset");

        // R10: full erase then sweep every word
        apply(1, 1, 1, 0, 0, '0, 8'h00, 1, 1, "R10 erase cycle");
        for (int i = 0; i < NW; i++) rd(AW'(i), "R10 erased word");

        // R3, R5, R2
        prog(6'd5, 8'hA5, "R3 program no drive");
        apply(0, 0, 1, 1, 1, 6'd5, 8'h00, 0, 1, "R5 verify");
        rd(6'd5, "R2 read programmed");

        // R4: ones cannot come back
        prog(6'd5, 8'hFF, "R4 program ones");
        rd(6'd5, "R4 unchanged");
        prog(6'd5, 8'h0F, "R4 program mask");
        rd(6'd5, "R4 and result");

        // R12: read right after write
        prog(6'd6, 8'h3C, "R12 program");
        rd(6'd6, "R12 next cycle read");

        // R6 inhibit
        apply(1, 0, 0, 1, 0, 6'd7, 8'h00, 0, 1, "R6 inhibit float");
        rd(6'd7, "R6 no write");

        // R7 standby and output disable
        apply(1, 0, 0, 0, 0, 6'd8, 8'h00, 0, 1, "R7 standby float");
        apply(0, 1, 0, 0, 0, 6'd8, 8'h00, 0, 1, "R7 out off float");
        apply(0, 1, 1, 1, 0, 6'd8, 8'h00, 0, 1, "R7 out off hv float");
        rd(6'd8, "R7 no write");

        // R11 illegal strobe combination
        apply(0, 0, 0, 1, 0, 6'd9, 8'h00, 0, 1, "R11 float");
        rd(6'd9, "R11 no write");

        // R8 identity and R9 float-zero after a driven value
        apply(0, 0, 1, 0, 1, 6'd0, 8'h00, 0, 1, "R8 maker code");
        apply(0, 0, 1, 0, 1, 6'd1, 8'h00, 0, 1, "R8 part code");
        apply(0, 0, 1, 0, 1, 6'd6, 8'h00, 0, 1, "R8 even addr maker");
        apply(0, 0, 1, 0, 1, 6'd5, 8'h00, 0, 1, "R8 odd addr part");
        apply(1, 1, 1, 0, 0, 6'd5, 8'h00, 0, 1, "R9 zero when float");

        // R10 erase beats program in the same cycle
        apply(0, 1, 0, 1, 0, 6'd5, 8'h00, 1, 1, "R10 erase over program");
        rd(6'd5, "R10 erased after conflict");
        rd(6'd6, "R10 other word erased");

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule